// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block lets a simple command port reach the 16-bit internal control registers of a PHY. Those registers sit behind a strobe/acknowledge interface: the block drives a 20-bit control word toward the PHY and watches one acknowledge bit and a 16-bit data field coming back. Every access is made of one or more strobe phases. In each phase a strobe is raised, the acknowledge must go high, the strobe is dropped, and the acknowledge must go low again before anything else happens.

Three commands exist: load an address, write data to the loaded address, and read from it. A write needs two phases in a row: the data is captured first and then committed. The block waits for the acknowledge by polling it at a parameterised tick interval. A bounded number of re-polls limits each wait, so a PHY that stops answering turns the command into an error pulse instead of a hang. Completion is shown by a one-cycle done pulse. Read data stays on a dedicated output until the next read.

Top module: `phy_cr_master`

## Requirements
- R1: The control word holds the value in bits 15:0 and a 4-bit strobe field in bits 19:16: bit 16 captures an address, bit 17 captures data, bit 18 commits a write, bit 19 requests a read. At most one strobe bit is high at any time. Command codes on cmd_op: 0 = address, 1 = write, 2 = read.
- R2: In every phase the strobe stays up until the acknowledge (status bit 18) is seen high. The strobe is then cleared while bits 15:0 are kept, and the next step waits for the acknowledge to be seen low. A strobe never rises while the acknowledge is high.
- R3: An address command makes exactly one capture-address phase carrying cmd_data. When it ends, the control word is the address with all strobes low.
- R4: A write command makes a capture-data phase on cmd_data and then a commit phase with the same low bits. When it ends, the control word is zero.
- R5: A read command raises the read strobe with bits 15:0 zero. It latches status bits 15:0 into rd_data when the acknowledge is seen high, and ends with the control word zero. rd_data does not change outside a read.
- R6: The acknowledge is checked on the first cycle of each wait and then again every TICKS cycles, for at most MAX_REPOLLS (100) re-polls. An acknowledge present at the last re-poll still succeeds. When the re-polls run out, the block pulses err, clears the control word, goes idle and gives no done. The error takes 100*TICKS+2 cycles from the command cycle to err.
- R7: A command is accepted only while busy is low. Commands offered while busy are ignored, and so is code 3 at any time.
- R8: done and err are one-cycle pulses, never high together, and busy is low whenever either is high.
- R9: While reset is held, the control word, busy, done, err and rd_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | Command code (0 address, 1 write, 2 read) |
| cmd_data | input | 16 | Address or write data |
| phy_status | input | 19 | PHY status: bit 18 acknowledge, bits 15:0 read data |
| phy_ctrl | output | 20 | Control word to the PHY |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Command completed (pulse) |
| err | output | 1 | Acknowledge timeout (pulse) |
| rd_data | output | 16 | Data from the last read |

## Verification
The hardest situations to reach are the acknowledge timeouts, in particular a timeout while the block is waiting for the acknowledge to fall, and the exact edge between the last allowed re-poll and one poll too late. The bench PHY model has a programmable acknowledge latency, a mute mode that never acknowledges, and a stuck mode that raises the acknowledge but never drops it. The latency is set to 100*TICKS-1 and to 100*TICKS cycles to land on either side of the limit, and the cycle count up to err is measured.

// File: rtl/phy_cr_pkg.sv
// Package: shared command codes and strobe-field encodings for the PHY
// control-register handshake master. Assumes a 4-bit strobe field placed
// directly above the data field of the control word.
package phy_cr_pkg;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_CAP_ADDR,
        PH_CAP_DATA,
        PH_COMMIT,
        PH_READ
    } phase_e;

    localparam int STB_W = 4;
    localparam logic [STB_W-1:0] STB_CAP_ADDR = 4'b0001;
    localparam logic [STB_W-1:0] STB_CAP_DATA = 4'b0010;
    localparam logic [STB_W-1:0] STB_COMMIT   = 4'b0100;
    localparam logic [STB_W-1:0] STB_READ     = 4'b1000;

endpackage

// File: rtl/phy_cr_poll_timer.sv
// Module: poll pacing for acknowledge waits. While active, it raises poll on
// the first cycle and then every TICKS cycles. It counts re-polls up to
// MAX_REPOLLS and flags the last one. restart or inactivity rewinds both
// counters. Assumes TICKS >= 1.
module phy_cr_poll_timer #(
    parameter int TICKS       = 4,
    parameter int MAX_REPOLLS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    output logic poll,
    output logic last_poll
);
    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam int PW = $clog2(MAX_REPOLLS + 1);

    logic [TW-1:0] tick_cnt;
    logic [PW-1:0] poll_cnt;

    // Advance the tick counter and the re-poll index.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || restart) begin
            tick_cnt <= '0;
            poll_cnt <= '0;
        end else if (tick_cnt == TW'(TICKS - 1)) begin
            tick_cnt <= '0;
            if (poll_cnt != PW'(MAX_REPOLLS)) poll_cnt <= poll_cnt + 1'b1;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // A poll is due when the tick counter sits at zero.
    always_comb begin
        poll      = active && (tick_cnt == '0);
        last_poll = (poll_cnt == PW'(MAX_REPOLLS));
    end
endmodule

// File: rtl/phy_cr_handshake_fsm.sv
// Module: sequences the strobe phases of one command (address, write, read).
// It drives the control word and reports done, err and rd_data. Assumes that
// poll/last_poll come from phy_cr_poll_timer and that ack is a level from the PHY.
module phy_cr_handshake_fsm
    import phy_cr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic [DATA_W-1:0]       cmd_data,
    input  logic                    ack,
    input  logic [DATA_W-1:0]       stat_data,
    input  logic                    poll,
    input  logic                    last_poll,
    output logic                    waiting,
    output logic                    advance,
    output logic [DATA_W+STB_W-1:0] ctl,
    output logic                    done,
    output logic                    err,
    output logic [DATA_W-1:0]       rd_data
);
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT_HI, ST_WAIT_LO} state_e;

    state_e state;
    phase_e phase;
    op_e    op_in;

    // Decode the command code and the step conditions.
    always_comb begin
        op_in   = op_e'(cmd_op);
        waiting = (state != ST_IDLE);
        advance = poll && (((state == ST_WAIT_HI) && ack) ||
                           ((state == ST_WAIT_LO) && !ack));
    end

    // Phase sequencer: accept, wait for ack high, wait for ack low, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_CAP_ADDR;
            ctl     <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid && op_in != OP_NONE) begin
                        state <= ST_WAIT_HI;
                        case (op_in)
                            OP_ADDR: begin
                                phase <= PH_CAP_ADDR;
                                ctl   <= {STB_CAP_ADDR, cmd_data};
                            end
                            OP_WRITE: begin
                                phase <= PH_CAP_DATA;
                                ctl   <= {STB_CAP_DATA, cmd_data};
                            end
                            default: begin
                                phase <= PH_READ;
                                ctl   <= {STB_READ, {DATA_W{1'b0}}};
                            end
                        endcase
                    end
                end
                ST_WAIT_HI: begin
                    if (advance) begin
                        if (phase == PH_READ) rd_data <= stat_data;
                        ctl[DATA_W+STB_W-1:DATA_W] <= '0;
                        state <= ST_WAIT_LO;
                    end else if (poll && last_poll) begin
                        ctl   <= '0;
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_WAIT_LO: begin
                    if (advance) begin
                        if (phase == PH_CAP_DATA) begin
                            ctl[DATA_W+STB_W-1:DATA_W] <= STB_COMMIT;
                            phase <= PH_COMMIT;
                            state <= ST_WAIT_HI;
                        end else begin
                            if (phase != PH_CAP_ADDR) ctl <= '0;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end else if (poll && last_poll) begin
                        ctl   <= '0;
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phy_cr_master.sv
// Module: top of the PHY control-register handshake master. It connects the
// phase sequencer to the poll timer. Assumes ACK_POS > DATA_W, so the status
// bits between the data field and the acknowledge are unused.
module phy_cr_master
    import phy_cr_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ACK_POS     = 18,
    parameter int TICKS       = 4,
    parameter int MAX_REPOLLS = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic [DATA_W-1:0]       cmd_data,
    input  logic [ACK_POS:0]        phy_status,
    output logic [DATA_W+STB_W-1:0] phy_ctrl,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic [DATA_W-1:0]       rd_data
);
    logic poll, last_poll, waiting, advance;
    logic unused_stat_bits;

    // Status bits between data and acknowledge carry nothing for this block.
    assign unused_stat_bits = ^phy_status[ACK_POS-1:DATA_W];
    assign busy = waiting;

    phy_cr_poll_timer #(
        .TICKS(TICKS),
        .MAX_REPOLLS(MAX_REPOLLS)
    ) u_timer (
        .clk(clk),
        .rst_n(rst_n),
        .active(waiting),
        .restart(advance),
        .poll(poll),
        .last_poll(last_poll)
    );

    phy_cr_handshake_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk(clk),
        .rst_n(rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op(cmd_op),
        .cmd_data(cmd_data),
        .ack(phy_status[ACK_POS]),
        .stat_data(phy_status[DATA_W-1:0]),
        .poll(poll),
        .last_poll(last_poll),
        .waiting(waiting),
        .advance(advance),
        .ctl(phy_ctrl),
        .done(done),
        .err(err),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/phy_cr_master_chk.sv
// Module: property checker for phy_cr_master, attached with bind. It watches
// only the ports of the top module.
module phy_cr_master_chk #(
    parameter int DATA_W  = 16,
    parameter int ACK_POS = 18
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ACK_POS:0]     phy_status,
    input logic [DATA_W+3:0]    phy_ctrl,
    input logic                 busy,
    input logic                 done,
    input logic                 err,
    input logic [DATA_W-1:0]    rd_data
);
    logic ack, stb_any;
    logic unused_chk;

    // Reduce the strobe field and pick out the acknowledge.
    assign ack        = phy_status[ACK_POS];
    assign stb_any    = |phy_ctrl[DATA_W+3:DATA_W];
    assign unused_chk = ^phy_status[ACK_POS-1:0];

    p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctrl[DATA_W+3:DATA_W]));

    p_rise_on_low_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_any && !$past(stb_any)) |-> !$past(ack));

    p_fall_on_high_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_any && $past(stb_any) && !err) |-> $past(ack));

    p_rd_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(rd_data));

    p_err_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (phy_ctrl == '0 && !busy));

    p_idle_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !stb_any);

    p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
endmodule

bind phy_cr_master phy_cr_master_chk #(
    .DATA_W(DATA_W),
    .ACK_POS(ACK_POS)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .phy_status(phy_status),
    .phy_ctrl(phy_ctrl),
    .busy(busy),
    .done(done),
    .err(err),
    .rd_data(rd_data)
);

// File: tb/tb_phy_cr_master.sv
module tb_phy_cr_master;
    localparam int TICKS = 2;
    localparam int LIMIT = 100 * TICKS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_data = 16'd0;
    logic [18:0] phy_status;
    logic [19:0] phy_ctrl;
    logic        busy, done, err;
    logic [15:0] rd_data;

    always #10 clk = ~clk;

    phy_cr_master #(.TICKS(TICKS)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .phy_status(phy_status), .phy_ctrl(phy_ctrl),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data));

    // PHY responder model: ack follows strobe level after lat cycles.
    // Mode 0 normal, 1 never acknowledges, 2 acknowledge never falls.
    int          lat = 0;
    int          mode = 0;
    int          cnt;
    logic        ack, prev_lvl, lvl;
    logic [15:0] m_addr, m_data, rdv;
    logic [15:0] mem [0:15];
    logic [19:0] stb_log [0:255];
    int          nstb;
    logic [19:0] last_clr;

    assign lvl        = |phy_ctrl[19:16];
    assign phy_status = {ack, 2'b00, rdv};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0; cnt <= 0; prev_lvl <= 1'b0; m_addr <= '0; m_data <= '0;
            rdv <= '0; nstb <= 0; last_clr <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else begin
            prev_lvl <= lvl;
            if (lvl && !prev_lvl) begin
                if (nstb < 256) stb_log[nstb] <= phy_ctrl;
                nstb <= nstb + 1;
                case (phy_ctrl[19:16])
                    4'b0001: m_addr <= phy_ctrl[15:0];
                    4'b0010: m_data <= phy_ctrl[15:0];
                    4'b0100: mem[m_addr[3:0]] <= m_data;
                    4'b1000: rdv <= mem[m_addr[3:0]];
                    default: ;
                endcase
            end
            if (!lvl && prev_lvl) last_clr <= phy_ctrl;
            if (mode == 1) begin
                ack <= 1'b0; cnt <= 0;
            end else if (lvl != ack && !(mode == 2 && ack)) begin
                if (cnt >= lat) begin ack <= lvl; cnt <= 0; end
                else cnt <= cnt + 1;
            end else begin
                cnt <= 0;
            end
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Issue one command and wait for done or err; cyc counts negedges.
    logic got_done, got_err;
    int   cyc;
    task automatic run_cmd(input logic [1:0] op, input logic [15:0] d);
        got_done = 1'b0; got_err = 1'b0; cyc = 0;
        cmd_op = op; cmd_data = d; cmd_valid = 1'b1;
        while (!got_done && !got_err && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            cmd_valid = 1'b0;
            got_done = done;
            got_err  = err;
        end
    endtask

    task automatic settle();
        repeat (lat + 4) @(negedge clk);
    endtask

    // Vector table: {op, data, expected}; expected is rd_data for reads,
    // final control-word low bits otherwise.
    localparam logic [33:0] VEC [10] = '{
        {2'd0, 16'h0003, 16'h0003},
        {2'd1, 16'hA5A5, 16'h0000},
        {2'd2, 16'h0000, 16'hA5A5},
        {2'd0, 16'h0005, 16'h0005},
        {2'd1, 16'h1234, 16'h0000},
        {2'd2, 16'h0000, 16'h1234},
        {2'd0, 16'h0003, 16'h0003},
        {2'd2, 16'h0000, 16'hA5A5},
        {2'd1, 16'h0000, 16'h0000},
        {2'd2, 16'h0000, 16'h0000}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int base;
        logic [1:0]  op;
        logic [15:0] d, e;
        int          nb;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(phy_ctrl == 0 && !busy && !done && !err && rd_data == 0, "R9 reset outputs",
              {phy_ctrl[15:0], 13'd0, busy, done, err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R3 R4 R5
        for (int i = 0; i < 10; i++) begin
            op = VEC[i][33:32]; d = VEC[i][31:16]; e = VEC[i][15:0];
            lat = (i % 4) * 3;
            base = nstb;
            run_cmd(op, d);
            check(got_done && !got_err, "R1 command completes", {30'd0, got_done, got_err}, 32'd2);
            nb = nstb - base;
            if (op == 2'd0) begin
                check(phy_ctrl == {4'b0000, e}, "R3 address held after access", phy_ctrl, {4'b0, e});
                check(nb == 1 && stb_log[base] == {4'b0001, d}, "R3 single capture-address phase",
                      {nb[11:0], stb_log[base]}, {12'd1, 4'b0001, d});
            end else if (op == 2'd1) begin
                check(phy_ctrl == 0, "R4 control word zero after write", phy_ctrl, 0);
                check(nb == 2 && stb_log[base] == {4'b0010, d} && stb_log[base+1] == {4'b0100, d},
                      "R4 capture then commit", {stb_log[base][19:16], stb_log[base+1]}, {4'b0010, 4'b0100, d});
                check(last_clr == {4'b0000, d}, "R2 low bits kept when strobe clears", last_clr, {4'b0, d});
            end else begin
                check(rd_data == e, "R5 read data", rd_data, e);
                check(phy_ctrl == 0 && stb_log[base] == 20'h80000, "R5 read strobe alone, end zero",
                      stb_log[base], 20'h80000);
            end
            settle();
        end

        // R7: reserved code ignored in idle
        lat = 2;
        cmd_op = 2'd3; cmd_data = 16'hFFFF; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        got_done = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (busy || done || phy_ctrl != 0) got_done = 1'b1;
        end
        check(!got_done, "R7 code 3 ignored", {31'd0, got_done}, 0);

        // R7: commands while busy ignored (addr 3 <- 5A5A, offered addr 7 dropped)
        lat = 10;
        run_cmd(2'd0, 16'h0003);
        settle();
        base = nstb;
        cmd_op = 2'd1; cmd_data = 16'h5A5A; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 2'd0; cmd_data = 16'h0007;
        repeat (4) @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0; got_done = 1'b0;
        while (!got_done && cyc < 2000) begin @(negedge clk); cyc++; got_done = done; end
        settle();
        nb = nstb - base;
        check(nb == 2, "R7 no extra phases while busy", nb, 2);
        run_cmd(2'd2, 16'h0000);
        check(rd_data == 16'h5A5A, "R7 address unchanged by ignored command", rd_data, 16'h5A5A);
        settle();

        // R6: boundary on the last re-poll
        lat = LIMIT - 1;
        run_cmd(2'd0, 16'h0003);
        check(got_done && !got_err, "R6 ack at last re-poll succeeds", {30'd0, got_done, got_err}, 2);
        settle();
        lat = LIMIT;
        run_cmd(2'd0, 16'h0003);
        check(got_err && !got_done, "R6 ack one poll late is an error", {30'd0, got_done, got_err}, 1);
        check(phy_ctrl == 0 && !busy, "R6 error clears control word", phy_ctrl, 0);
        settle();

        // R6: mute PHY, measure time to error; R8 err pulse
        mode = 1; lat = 0;
        run_cmd(2'd1, 16'hBEEF);
        check(got_err && !got_done, "R6 mute PHY gives error", {30'd0, got_done, got_err}, 1);
        check(cyc == LIMIT + 2, "R6 error timing", cyc, LIMIT + 2);
        @(negedge clk);
        check(!err && !done, "R8 err is a single-cycle pulse", {30'd0, done, err}, 0);
        mode = 0;
        settle();

        // R6: acknowledge stuck high -> timeout while waiting for it to fall
        mode = 2; lat = 1;
        run_cmd(2'd0, 16'h0009);
        check(got_err && !got_done, "R6 stuck-high ack gives error", {30'd0, got_done, got_err}, 1);
        check(phy_ctrl == 0, "R6 control word zero after stuck ack", phy_ctrl, 0);
        mode = 0;
        settle();

        // R8: block recovers after errors; done is one cycle
        run_cmd(2'd0, 16'h0003);
        settle();
        run_cmd(2'd2, 16'h0000);
        check(got_done && rd_data == 16'h5A5A, "R8 recovers after error", rd_data, 16'h5A5A);
        @(negedge clk);
        check(!done && !busy, "R8 done is a single-cycle pulse", {30'd0, done, busy}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule